// File: doc/BRIEF.md
# Beam Self-Alignment Controller

This block closes a digital feedback loop that walks an optical beam onto the middle cell of a three-by-three photodetector grid. It does this by tilting a two-axis mirror. The mirror is moved by four electrodes. The controller holds a 12-bit drive code for each electrode, and an external converter turns each code into a voltage. Each electrode pair tilts the beam along one signed axis.

Every control iteration begins with a single-cycle valid pulse that carries all nine power samples at once. The controller picks the cell with the strongest sample as the beam position. It then chooses one correction:

- The horizontal axis is corrected first.
- The vertical axis is corrected only when the beam already sits in the middle column.

The correction adds a programmable step to the two electrodes of the chosen pair. When the centre sample reaches a programmable threshold, the loop reports alignment and stops stepping. If power later drops below the threshold, stepping starts again. Codes clip at full scale. A clip raises a sticky range flag instead of letting the code wrap.

Top module: `beam_align_ctrl`

## Requirements
- R1: A synchronous, active-high reset sets all four electrode codes to zero and clears `aligned` and `range_err` at the next clock edge.
- R2: On a clock edge where `smp_valid` is low, the codes, `aligned` and `range_err` keep their values, whatever the other inputs are.
- R3: The beam cell is the index of the largest sample. Sample k sits at bits [k*12 +: 12] of `smp_data`, and k = row*3 + col. Column 0 is the negative-x side and row 0 is the negative-y side. If two or more samples tie for largest, the lowest index wins.
- R4: If the beam cell is in column 0, the step is added to electrodes 1 and 2 (positive x). If it is in column 2, the step is added to electrodes 3 and 4 (negative x). Electrode n occupies bits [(n-1)*12 +: 12] of `elec_code`.
- R5: The x axis takes priority over the y axis. A beam cell in column 1 and row 0 adds the step to electrodes 2 and 3 (positive y). A beam cell in column 1 and row 2 adds it to electrodes 1 and 4 (negative y). A corner cell is corrected along x only.
- R6: If the beam cell is the centre cell (index 4) and the centre sample is below the threshold, no code changes.
- R7: On a valid pulse whose centre sample (index 4) is greater than or equal to `thresh`, `aligned` becomes 1 at that edge and no code changes.
- R8: On a valid pulse whose centre sample is below `thresh`, `aligned` becomes 0 at that edge, and the correction for that same iteration is applied.
- R9: A code whose sum with the step exceeds 4095 is set to 4095, and `range_err` is set. `range_err` then stays set until reset.
- R10: One iteration changes at most two codes. Each changed code grows by exactly `step`, or clips to 4095, and no code ever decreases outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One-cycle pulse starting a control iteration |
| smp_data | input | 108 | Nine 12-bit power samples, sample k at bits [k*12 +: 12] |
| step | input | 12 | Code increment applied per iteration |
| thresh | input | 12 | Centre power needed for alignment |
| elec_code | output | 48 | Electrode n drive code at bits [(n-1)*12 +: 12] |
| aligned | output | 1 | Centre power met the threshold on the last iteration |
| range_err | output | 1 | Sticky: some code was clipped at full scale |

## Verification
The assertions assume the following about the inputs:

- Reset is held high from time zero until after the first clock edge.
- Inputs never carry unknown values.
- `smp_data`, `step` and `thresh` are only meaningful in the cycle where `smp_valid` is high.

The bench changes inputs only on the falling edge. It holds reset from the start. Outside the directed cases, it drives idle cycles with fresh random samples so that ignored inputs really do change. Random threshold and step values are kept in a range that mixes aligned, stepping and clipping iterations.

// File: rtl/beam_align_pkg.sv
package beam_align_pkg;

   localparam int GRID_N   = 3;
   localparam int CELLS    = GRID_N * GRID_N;
   localparam int CENTRE   = CELLS / 2;
   localparam int IDX_W    = $clog2(CELLS);
   localparam int N_ELEC   = 4;

   typedef enum logic [2:0] {
      MOVE_NONE,
      MOVE_POS_X,
      MOVE_NEG_X,
      MOVE_POS_Y,
      MOVE_NEG_Y
   } move_e;

   // bit n-1 selects electrode n
   function automatic logic [N_ELEC-1:0] move_mask(move_e m);
      case (m)
         MOVE_POS_X: return 4'b0011;
         MOVE_NEG_X: return 4'b1100;
         MOVE_POS_Y: return 4'b0110;
         MOVE_NEG_Y: return 4'b1001;
         default:    return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/beam_peak_locator.sv
module beam_peak_locator
   import beam_align_pkg::*;
#(
   parameter int SAMPLE_W = 12
) (
   input  logic [CELLS*SAMPLE_W-1:0] samples,
   output logic [IDX_W-1:0]          peak_idx,
   output logic [SAMPLE_W-1:0]       peak_val
);

   logic [SAMPLE_W-1:0] run_v [CELLS];
   logic [IDX_W-1:0]    run_i [CELLS];

   assign run_v[0] = samples[0 +: SAMPLE_W];
   assign run_i[0] = '0;

   // strict compare keeps the earlier index on a tie
   for (genvar g = 1; g < CELLS; g++) begin : g_chain
      logic [SAMPLE_W-1:0] cur;
      assign cur      = samples[g*SAMPLE_W +: SAMPLE_W];
      assign run_v[g] = (cur > run_v[g-1]) ? cur : run_v[g-1];
      assign run_i[g] = (cur > run_v[g-1]) ? IDX_W'(g) : run_i[g-1];
   end

   assign peak_idx = run_i[CELLS-1];
   assign peak_val = run_v[CELLS-1];

   always_comb begin
      for (int i = 0; i < CELLS; i++) begin
         assert_peak_max_R3: assert (peak_val >= samples[i*SAMPLE_W +: SAMPLE_W])
            else $error("peak value below sample %0d", i);
      end
   end

endmodule

// File: rtl/beam_dir_decoder.sv
module beam_dir_decoder
   import beam_align_pkg::*;
(
   input  logic [IDX_W-1:0]  peak_idx,
   input  logic              go,
   output move_e             move,
   output logic [N_ELEC-1:0] mask
);

   always_comb begin
      move = MOVE_NONE;
      if (go) begin
         // x axis first: any non-middle column is a horizontal move
         case (peak_idx)
            4'd0, 4'd3, 4'd6: move = MOVE_POS_X;
            4'd2, 4'd5, 4'd8: move = MOVE_NEG_X;
            4'd1:             move = MOVE_POS_Y;
            4'd7:             move = MOVE_NEG_Y;
            default:          move = MOVE_NONE;
         endcase
      end
   end

   assign mask = move_mask(move);

   always_comb begin
      assert_pair_only_R4: assert ($countones(mask) == 0 || $countones(mask) == 2)
         else $error("electrode mask not a pair");
   end

endmodule

// File: rtl/beam_elec_reg.sv
module beam_elec_reg #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bump,
   input  logic [CODE_W-1:0] step,
   output logic [CODE_W-1:0] code,
   output logic              clip
);

   localparam logic [CODE_W:0] FULL = {1'b0, {CODE_W{1'b1}}};

   logic [CODE_W:0] sum;

   assign sum  = {1'b0, code} + {1'b0, step};
   assign clip = bump && (sum > FULL);

   always_ff @(posedge clk) begin
      if (rst)
         code <= '0;
      else if (bump)
         code <= (sum > FULL) ? FULL[CODE_W-1:0] : sum[CODE_W-1:0];
   end

   assert_no_decrease_R10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> code >= $past(code))
      else $error("electrode code decreased");

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !bump |=> $stable(code))
      else $error("electrode code moved without a bump");

endmodule

// File: rtl/beam_align_ctrl.sv
module beam_align_ctrl
   import beam_align_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int CODE_W   = 12
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      smp_valid,
   input  logic [CELLS*SAMPLE_W-1:0] smp_data,
   input  logic [CODE_W-1:0]         step,
   input  logic [SAMPLE_W-1:0]       thresh,
   output logic [N_ELEC*CODE_W-1:0]  elec_code,
   output logic                      aligned,
   output logic                      range_err
);

   if (SAMPLE_W < 2 || SAMPLE_W > 24) begin : g_bad_sample_w
      $error("SAMPLE_W out of supported range");
   end
   if (CODE_W < 2 || CODE_W > 24) begin : g_bad_code_w
      $error("CODE_W out of supported range");
   end

   logic [SAMPLE_W-1:0] centre_pwr;
   logic                meets;
   logic                go;
   logic [IDX_W-1:0]    peak_idx;
   logic [SAMPLE_W-1:0] peak_val;
   move_e               move;
   logic [N_ELEC-1:0]   mask;
   logic [N_ELEC-1:0]   clip;

   assign centre_pwr = smp_data[CENTRE*SAMPLE_W +: SAMPLE_W];
   assign meets      = centre_pwr >= thresh;
   assign go         = smp_valid && !meets;

   beam_peak_locator #(.SAMPLE_W(SAMPLE_W)) peak_i (
      .samples  (smp_data),
      .peak_idx (peak_idx),
      .peak_val (peak_val)
   );

   beam_dir_decoder dir_i (
      .peak_idx (peak_idx),
      .go       (go),
      .move     (move),
      .mask     (mask)
   );

   for (genvar e = 0; e < N_ELEC; e++) begin : g_elec
      beam_elec_reg #(.CODE_W(CODE_W)) reg_i (
         .clk  (clk),
         .rst  (rst),
         .bump (mask[e]),
         .step (step),
         .code (elec_code[e*CODE_W +: CODE_W]),
         .clip (clip[e])
      );
   end

   // R1: reset clears flags; R9: clip is sticky
   always_ff @(posedge clk) begin
      if (rst) begin
         aligned   <= 1'b0;
         range_err <= 1'b0;
      end else begin
         if (smp_valid) aligned <= meets;
         if (|clip)     range_err <= 1'b1;
      end
   end

   assert_aligned_freeze_R7: assert property (@(posedge clk) disable iff (rst)
      smp_valid && centre_pwr >= thresh |=> aligned && $stable(elec_code))
      else $error("step applied while aligned");

   assert_lost_alignment_R8: assert property (@(posedge clk) disable iff (rst)
      smp_valid && centre_pwr < thresh |=> !aligned)
      else $error("aligned held below threshold");

   assert_sticky_err_R9: assert property (@(posedge clk) disable iff (rst)
      range_err |=> range_err)
      else $error("range flag dropped");

   assert_idle_flags_R2: assert property (@(posedge clk) disable iff (rst)
      !smp_valid |=> $stable(aligned) && $stable(elec_code))
      else $error("state moved without valid");

endmodule

// File: tb/beam_align_ctrl_tb_top.sv
module beam_align_ctrl_tb_top;

   localparam int SW   = 12;
   localparam int CW   = 12;
   localparam int FULL = (1 << CW) - 1;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst       = 1'b1;
   logic            smp_valid = 1'b0;
   logic [9*SW-1:0] smp_data  = '0;
   logic [CW-1:0]   step      = '0;
   logic [SW-1:0]   thresh    = '0;
   logic [4*CW-1:0] elec_code;
   logic            aligned, range_err;

   int m_code [4];
   bit m_al, m_err;
   int s [9];
   int checks = 0, errors = 0;
   bit done = 0;

   beam_align_ctrl #(.SAMPLE_W(SW), .CODE_W(CW)) dut_i (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
      .step(step), .thresh(thresh), .elec_code(elec_code),
      .aligned(aligned), .range_err(range_err)
   );

   task automatic model_update(bit r, bit v);
      int best, idx, col, row, t;
      bit [3:0] sel;
      if (r) begin
         for (int k = 0; k < 4; k++) m_code[k] = 0;
         m_al = 0; m_err = 0;
      end else if (v) begin
         best = -1; idx = 0;
         for (int i = 0; i < 9; i++) if (s[i] > best) begin best = s[i]; idx = i; end
         col = idx % 3; row = idx / 3;
         m_al = (s[4] >= int'(thresh));
         sel = 4'b0000;
         if (!m_al) begin
            if (col == 0)      sel = 4'b0011;
            else if (col == 2) sel = 4'b1100;
            else if (row == 0) sel = 4'b0110;
            else if (row == 2) sel = 4'b1001;
         end
         for (int k = 0; k < 4; k++) if (sel[k]) begin
            t = m_code[k] + int'(step);
            if (t > FULL) begin t = FULL; m_err = 1; end
            m_code[k] = t;
         end
      end
   endtask

   task automatic compare(string tag);
      logic [4*CW-1:0] exp_bus;
      for (int k = 0; k < 4; k++) exp_bus[k*CW +: CW] = m_code[k][CW-1:0];
      checks++;
      if (elec_code !== exp_bus || aligned !== m_al || range_err !== m_err) begin
         errors++;
         $display("FAIL %s: codes %h aligned %0b err %0b, expected codes %h aligned %0b err %0b",
                  tag, elec_code, aligned, range_err, exp_bus, m_al, m_err);
      end
   endtask

   task automatic tick(bit r, bit v, string tag);
      @(negedge clk);
      rst = r; smp_valid = v;
      for (int i = 0; i < 9; i++) smp_data[i*SW +: SW] = s[i][SW-1:0];
      model_update(r, v);
      @(posedge clk);
      #1;
      compare(tag);
   endtask

   task automatic fill_low();
      for (int i = 0; i < 9; i++) s[i] = int'($urandom_range(0, 99));
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog (all requirements): run hung, got no finish, expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      string tg;
      for (int i = 0; i < 9; i++) s[i] = 0;
      thresh = 12'd4000; step = 12'd100;
      tick(1, 0, "R1");
      tick(1, 0, "R1");

      // idle cycles with changing inputs
      for (int n = 0; n < 3; n++) begin fill_low(); s[0] = 3000; tick(0, 0, "R2"); end

      // peak in each cell
      for (int idx = 0; idx < 9; idx++) begin
         fill_low(); s[idx] = 2000;
         if (idx == 4)          tg = "R6";
         else if (idx % 3 != 1) tg = "R4";
         else                   tg = "R5";
         tick(0, 1, tg);
         fill_low();
         tick(0, 0, "R2");
      end

      // ties go to the lowest index
      for (int i = 0; i < 9; i++) s[i] = 5;
      s[0] = 300; s[2] = 300;
      tick(0, 1, "R3");
      for (int i = 0; i < 9; i++) s[i] = 5;
      s[8] = 300; s[6] = 300; s[7] = 300;
      tick(0, 1, "R3");

      // corner cell: x only
      fill_low(); s[8] = 1500;
      tick(0, 1, "R5");
      fill_low(); s[0] = 1500;
      tick(0, 1, "R5");

      // alignment at equality, then loss with immediate step
      thresh = 12'd500;
      fill_low(); s[0] = 900; s[4] = 500;
      tick(0, 1, "R7");
      fill_low(); tick(0, 0, "R7");
      fill_low(); s[0] = 900; s[4] = 499;
      tick(0, 1, "R8");
      fill_low(); s[4] = 600;
      tick(0, 1, "R7");
      fill_low(); s[5] = 900; s[4] = 10;
      tick(0, 1, "R8");

      // saturation and sticky range flag
      thresh = 12'd4000; step = 12'd1500;
      for (int n = 0; n < 4; n++) begin fill_low(); s[3] = 3000; tick(0, 1, "R9"); end
      for (int n = 0; n < 2; n++) begin fill_low(); tick(0, 0, "R9"); end
      fill_low(); s[4] = 4095;
      tick(0, 1, "R9");

      // reset mid-run
      tick(1, 0, "R1");
      tick(0, 0, "R1");

      // mixed random traffic
      for (int n = 0; n < 600; n++) begin
         for (int i = 0; i < 9; i++) s[i] = int'($urandom_range(0, 4095));
         thresh = 12'($urandom_range(2500, 4095));
         step   = 12'($urandom_range(0, 400));
         tick(0, ($urandom_range(0, 3) != 0), "R10");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule